// File: doc/BRIEF.md
# Packed Vector Attribute Loader

This block listens to a 32-bit register write bus and fills a table of sixteen four-component vectors, where every component is a 24-bit floating-point value kept as raw bits. Software sends a vector as three 32-bit data words. The block holds the first two words. When the third word arrives, it splits the 96 bits into four 24-bit components and writes the vector into the table slot that a separate index register selects.

The index register can be loaded directly and advances by one after every stored vector, so a stream of word triples fills consecutive slots. An index at or past the end of the table makes the block drop the vector and raise an error pulse. A registered read port returns any stored vector for the consumer or a test harness.

Top module: `vla_loader`

## Requirements
- R1: A write to any of the addresses 0x233, 0x234 or 0x235 is a data word. All three addresses feed the same word collector in the same way, and a triple may mix them freely.
- R2: Data words are collected in arrival order. The third word of a triple commits the vector, and the collector then starts a new triple.
- R3: With the words of a triple named a, b and c in arrival order, the stored vector is w = a[31:8], z = {a[7:0], b[31:16]}, y = {b[15:0], c[31:24]} and x = c[23:0]. On rd_data it appears as {x, y, z, w}, with x in bits [95:72] and w in bits [23:0].
- R4: A commit with an index below 16 writes the slot named by that index, and slot_idx then reads one higher.
- R5: A commit with an index of 16 or more writes no slot and leaves slot_idx unchanged. The collector still starts a new triple.
- R6: A write to address 0x232 loads slot_idx from wr_data[4:0]. It does not disturb a partly collected triple.
- R7: A write to any other address, and any cycle without wr_en, leaves the collector, the index and the table unchanged.
- R8: rd_data shows the slot named by rd_addr one clock after it is sampled. If that slot is written in the same cycle, rd_data shows the old contents.
- R9: After reset, slot_idx is 0, the collector is empty, both pulses are low and every slot reads as zero.
- R10: commit_pulse is high for exactly the one cycle after the edge that stores a vector. drop_pulse is high for exactly the one cycle after the edge that drops one. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Slot to read |
| rd_data | output | 96 | Stored vector {x, y, z, w}, registered |
| slot_idx | output | 5 | Current target index |
| commit_pulse | output | 1 | A vector was stored |
| drop_pulse | output | 1 | A vector was dropped because the index was out of range |

## Verification
A table write from a completed triple and a read of the table can land in the same cycle. The bench provokes this in a directed case: it finishes a triple while rd_addr points at the slot being filled. It then checks that rd_data first shows the old vector and shows the new one on the following cycle. Random traffic also sends reads into cycles next to commits. An index load and a commit cannot coincide, because they share the single write bus. For that reason the bench instead places index loads between the words of a triple and checks that the triple still completes into the newly named slot.

// File: rtl/vla_pkg.sv
package vla_pkg;
    parameter int WORD_W = 32;
    parameter int COMP_W = 24;
    parameter int VEC_W  = 4 * COMP_W;

    // x sits in the most significant lane, w in the least
    typedef struct packed {
        logic [COMP_W-1:0] x;
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] z;
        logic [COMP_W-1:0] w;
    } vec_t;
endpackage

// File: rtl/vla_decode.sv
module vla_decode #(
    parameter int ADDR_W    = 10,
    parameter int DATA_BASE = 'h233,
    parameter int DATA_REGS = 3,
    parameter int IDX_ADDR  = 'h232
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              data_hit,
    output logic              idx_hit
);
    logic [DATA_REGS-1:0] lane_hit;

    for (genvar i = 0; i < DATA_REGS; i++) begin : g_lane
        assign lane_hit[i] = wr_en && (wr_addr == ADDR_W'(DATA_BASE + i));
    end

    assign data_hit = |lane_hit;
    assign idx_hit  = wr_en && (wr_addr == ADDR_W'(IDX_ADDR));
endmodule

// File: rtl/vla_collect.sv
module vla_collect #(
    parameter int WORD_W = 32,
    parameter int SLOTS  = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_hit,
    input  logic              idx_hit,
    input  logic [WORD_W-1:0] wr_data,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b,
    output logic              commit_pulse,
    output logic              drop_pulse
);
    localparam int              WORDS   = 3;
    localparam logic [1:0]      LAST    = 2'(WORDS - 1);
    localparam logic [IDX_W:0]  SLOTS_L = (IDX_W + 1)'(SLOTS);

    typedef struct packed {
        logic [1:0]        cnt;
        logic [WORD_W-1:0] wa;
        logic [WORD_W-1:0] wb;
        logic [IDX_W-1:0]  idx;
        logic              commit;
        logic              drop;
    } st_t;

    st_t  st_d, st_q;
    logic in_range;

    assign in_range = ({1'b0, st_q.idx} < SLOTS_L);

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        st_d.drop   = 1'b0;
        tbl_we      = 1'b0;
        if (data_hit) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                if (in_range) begin
                    tbl_we      = 1'b1;
                    st_d.idx    = st_q.idx + 1'b1;
                    st_d.commit = 1'b1;
                end else begin
                    st_d.drop = 1'b1;
                end
            end else begin
                if (st_q.cnt == 2'd0) begin
                    st_d.wa = wr_data;
                end else begin
                    st_d.wb = wr_data;
                end
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (idx_hit) begin
            st_d.idx = wr_data[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx          = st_q.idx;
    assign word_a       = st_q.wa;
    assign word_b       = st_q.wb;
    assign commit_pulse = st_q.commit;
    assign drop_pulse   = st_q.drop;
endmodule

// File: rtl/vla_unpack.sv
module vla_unpack
    import vla_pkg::*;
(
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic [WORD_W-1:0] word_c,
    output vec_t              vec
);
    // 3 x 32 bits regrouped as 4 x 24 bits; the first lane from the top is w
    logic [VEC_W-1:0]  cat;
    logic [COMP_W-1:0] comp [4];

    assign cat = {word_a, word_b, word_c};

    for (genvar k = 0; k < 4; k++) begin : g_comp
        assign comp[k] = cat[VEC_W-1-k*COMP_W -: COMP_W];
    end

    assign vec.w = comp[0];
    assign vec.z = comp[1];
    assign vec.y = comp[2];
    assign vec.x = comp[3];
endmodule

// File: rtl/vla_table.sv
module vla_table
    import vla_pkg::*;
#(
    parameter int SLOTS   = 16,
    parameter int SLOT_AW = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [SLOT_AW-1:0] wslot,
    input  vec_t               wvec,
    input  logic [SLOT_AW-1:0] rd_addr,
    output logic [VEC_W-1:0]   rd_data
);
    typedef struct packed {
        logic [SLOTS-1:0][VEC_W-1:0] mem;
        logic [VEC_W-1:0]            rd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        // read takes the registered contents, so a same-cycle write is not seen
        st_d.rd = st_q.mem[rd_addr];
        if (we) begin
            st_d.mem[wslot] = wvec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;
endmodule

// File: rtl/vla_loader.sv
module vla_loader
    import vla_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_BASE = 'h233,
    parameter int DATA_REGS = 3,
    parameter int IDX_ADDR  = 'h232,
    parameter int SLOTS     = 16,
    parameter int IDX_W     = 5,
    parameter int SLOT_AW   = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [SLOT_AW-1:0] rd_addr,
    output logic [95:0]        rd_data,
    output logic [IDX_W-1:0]   slot_idx,
    output logic               commit_pulse,
    output logic               drop_pulse
);
    logic              data_hit, idx_hit, tbl_we;
    logic [WORD_W-1:0] word_a, word_b;
    vec_t              vec;

    vla_decode #(
        .ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE),
        .DATA_REGS(DATA_REGS), .IDX_ADDR(IDX_ADDR)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr),
        .data_hit(data_hit), .idx_hit(idx_hit)
    );

    vla_collect #(.WORD_W(WORD_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_col (
        .clk(clk), .rst_n(rst_n),
        .data_hit(data_hit), .idx_hit(idx_hit), .wr_data(wr_data),
        .tbl_we(tbl_we), .idx(slot_idx),
        .word_a(word_a), .word_b(word_b),
        .commit_pulse(commit_pulse), .drop_pulse(drop_pulse)
    );

    vla_unpack u_unp (
        .word_a(word_a), .word_b(word_b), .word_c(wr_data), .vec(vec)
    );

    vla_table #(.SLOTS(SLOTS), .SLOT_AW(SLOT_AW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .wslot(slot_idx[SLOT_AW-1:0]), .wvec(vec),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/vla_chk.sv
module vla_chk #(
    parameter int SLOTS = 16,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] slot_idx,
    input logic             commit_pulse,
    input logic             drop_pulse
);
    localparam logic [IDX_W:0] SLOTS_L = (IDX_W + 1)'(SLOTS);

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_pulse && drop_pulse));

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> slot_idx == IDX_W'($past(slot_idx) + 1'b1));

    // R4
    commit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> ({1'b0, $past(slot_idx)} < SLOTS_L));

    // R5
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> ($stable(slot_idx) && ({1'b0, slot_idx} >= SLOTS_L)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(slot_idx) && !commit_pulse && !drop_pulse));
endmodule

bind vla_loader vla_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot_idx(slot_idx),
    .commit_pulse(commit_pulse), .drop_pulse(drop_pulse)
);

// File: tb/sim_vla_loader.sv
module sim_vla_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [95:0] rd_data;
    logic [4:0]  slot_idx;
    logic        commit_pulse, drop_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [95:0] m_mem [16];
    logic [31:0] m_buf [2];
    int          m_cnt;
    logic [4:0]  m_idx;

    always #4 clk = ~clk;

    vla_loader u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .slot_idx(slot_idx), .commit_pulse(commit_pulse), .drop_pulse(drop_pulse)
    );

    function automatic logic [95:0] pack_vec(logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic [23:0] x, y, z, w;
        w = a[31:8];
        z = {a[7:0], b[31:16]};
        y = {b[15:0], c[31:24]};
        x = c[23:0];
        return {x, y, z, w};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input string req);
        bit ec, ed;
        ec = 1'b0;
        ed = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a >= 10'h233 && a <= 10'h235) begin
            if (m_cnt == 2) begin
                m_cnt = 0;
                if (m_idx < 5'd16) begin
                    m_mem[m_idx[3:0]] = pack_vec(m_buf[0], m_buf[1], d);
                    m_idx = m_idx + 1'b1;
                    ec = 1'b1;
                end else begin
                    ed = 1'b1;
                end
            end else begin
                m_buf[m_cnt] = d;
                m_cnt++;
            end
        end else if (a == 10'h232) begin
            m_idx = d[4:0];
        end
        chk(commit_pulse == ec, {req, " R10 commit_pulse"}, 96'(commit_pulse), 96'(ec));
        chk(drop_pulse == ed, {req, " R10 drop_pulse"}, 96'(drop_pulse), 96'(ed));
        chk(slot_idx == m_idx, {req, " slot_idx"}, 96'(slot_idx), 96'(m_idx));
    endtask

    task automatic rd(input logic [3:0] s, input string req);
        @(negedge clk);
        rd_addr = s;
        @(negedge clk);
        chk(rd_data == m_mem[s], {req, " rd_data"}, rd_data, m_mem[s]);
        chk(!commit_pulse && !drop_pulse, "R7 idle pulses", 96'({commit_pulse, drop_pulse}), 96'(0));
    endtask

    task automatic triple(input logic [9:0] a0, input logic [9:0] a1, input logic [9:0] a2, input string req);
        wr(a0, $urandom, req);
        wr(a1, $urandom, req);
        wr(a2, $urandom, req);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [95:0] old_v;
        logic [31:0] a, b, c;
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        m_cnt = 0;
        m_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk(slot_idx == 5'd0, "R9 idx after reset", 96'(slot_idx), 96'(0));
        chk(!commit_pulse && !drop_pulse, "R9 pulses after reset", 96'({commit_pulse, drop_pulse}), 96'(0));
        for (int s = 0; s < 16; s++) rd(4'(s), "R9 slot zero");

        // R1 R3: mixed addresses, known pattern
        wr(10'h233, 32'h11223344, "R1");
        wr(10'h234, 32'h55667788, "R1");
        wr(10'h235, 32'h99AABBCC, "R2");
        rd(4'd0, "R3 known pattern");
        chk(rd_data == 96'hAABBCC_778899_445566_112233, "R3 literal",
            rd_data, 96'hAABBCC_778899_445566_112233);

        // R1 R4: all on one address, next slot
        triple(10'h235, 10'h235, 10'h235, "R4");
        rd(4'd1, "R4 second slot");
        triple(10'h234, 10'h233, 10'h234, "R1");
        rd(4'd2, "R1 mixed order");

        // R6: index load between words keeps partial triple
        wr(10'h233, 32'hCAFEF00D, "R6");
        wr(10'h232, 32'hFFFF_FFEF, "R6 load 15");
        wr(10'h234, 32'h01234567, "R6");
        wr(10'h235, 32'h89ABCDEF, "R6");
        rd(4'd15, "R6 slot 15");

        // R5: index 16 drops, counter still restarts
        triple(10'h233, 10'h233, 10'h233, "R5 drop");
        for (int s = 0; s < 16; s++) rd(4'(s), "R5 table untouched");
        wr(10'h232, 32'd2, "R5 reload");
        triple(10'h235, 10'h234, 10'h233, "R5 after drop");
        rd(4'd2, "R5 restarted triple");
        wr(10'h232, 32'd31, "R5 idx 31");
        triple(10'h234, 10'h234, 10'h234, "R5 drop at 31");

        // R7: unrelated addresses between words
        wr(10'h232, 32'd5, "R7");
        wr(10'h233, 32'h0BADBEEF, "R7");
        wr(10'h236, 32'hFFFFFFFF, "R7 other addr");
        wr(10'h000, 32'h12345678, "R7 other addr");
        wr(10'h231, 32'h0, "R7 other addr");
        wr(10'h233, 32'h5A5A5A5A, "R7");
        wr(10'h233, 32'hA5A5A5A5, "R7");
        rd(4'd5, "R7 triple intact");

        // R8: read of slot being written in the same cycle
        wr(10'h233, 32'h13579BDF, "R8");
        wr(10'h234, 32'h2468ACE0, "R8");
        old_v = m_mem[6];
        @(negedge clk);
        rd_addr = 4'd6;
        wr_en = 1'b1; wr_addr = 10'h235; wr_data = 32'hFEDCBA98;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == old_v, "R8 old contents", rd_data, old_v);
        m_mem[6] = pack_vec(32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98);
        m_idx = 5'd7;
        m_cnt = 0;
        chk(commit_pulse == 1'b1, "R10 commit on R8 case", 96'(commit_pulse), 96'(1));
        @(negedge clk);
        chk(rd_data == m_mem[6], "R8 new contents next cycle", rd_data, m_mem[6]);
        chk(commit_pulse == 1'b0, "R10 single cycle", 96'(commit_pulse), 96'(0));

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [9:0] oa;
            r = int'($urandom % 10);
            if (r < 6) begin
                wr(10'(10'h233 + ($urandom % 3)), $urandom, "R2 random");
            end else if (r == 6) begin
                wr(10'h232, ($urandom & 32'hFFFF_FFE0) | ($urandom % 18), "R6 random");
            end else if (r == 7) begin
                oa = 10'($urandom);
                if (oa >= 10'h232 && oa <= 10'h235) oa = 10'h100;
                wr(oa, $urandom, "R7 random");
            end else begin
                rd(4'($urandom), "R3 random");
            end
        end
        for (int s = 0; s < 16; s++) rd(4'(s), "R3 final sweep");

        // keep a, b, c in use for a last directed vector
        a = 32'h00000001; b = 32'h80000000; c = 32'h00FFFFFF;
        wr(10'h232, 32'd9, "R6");
        wr(10'h233, a, "R3 edge bits");
        wr(10'h233, b, "R3 edge bits");
        wr(10'h233, c, "R3 edge bits");
        rd(4'd9, "R3 edge bits");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule